// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a decoded memory-operand description into the address a 16-bit segmented processor would place on its bus. A decoder supplies an addressing-mode code, which pointer registers take part, and a displacement. The block reads the current values of the two base pointers (BX, BP), the two index pointers (SI, DI) and the four segment registers (ES, CS, SS, DS). It forms a 16-bit offset, picks a segment, and returns a 20-bit physical address. A flag tells the consumer whether a memory access is needed at all.

The default segment depends on the registers used. Any form that uses BP defaults to the stack segment. Every other memory form defaults to the data segment. An override input can replace that choice. Results leave through a one-entry registered stage with valid/ready handshakes on both sides, so the block can sit between a decoder and an operand-fetch unit without extra buffering.

Top module: `agu_ea_unit`

## Requirements
- R1: Mode code 2 (direct) produces an offset equal to the full 16-bit `disp`, with the data segment (code 3) unless overridden.
- R2: Mode code 3 (register indirect) takes the offset from the register picked by `ind_sel` (0 BX, 1 BP, 2 SI, 3 DI). The segment is stack (code 2) for BP and data (code 3) for the rest.
- R3: Mode code 4 (based) produces BX (`base_sel`=0) or BP (`base_sel`=1) plus the displacement. When `disp_wide`=0, only `disp[7:0]` is used, sign-extended to 16 bits. When `disp_wide`=1, all 16 bits are used. BP selects the stack segment and BX selects the data segment.
- R4: Mode code 5 (indexed) produces SI (`idx_sel`=0) or DI (`idx_sel`=1) plus the displacement, extended as in R3, in the data segment.
- R5: Mode code 6 (based-indexed) produces the selected base plus the selected index, with no displacement. The segment is stack when the base is BP and data otherwise.
- R6: All offset sums wrap modulo 2^16.
- R7: `out_phys` equals (segment value × 16 + offset) modulo 2^20. The segment value is ES, CS, SS or DS for segment codes 0, 1, 2, 3 respectively.
- R8: For memory modes, when `seg_ovr_en`=1, `out_seg_sel` and the segment used in R7 come from `seg_ovr_sel` instead of the default.
- R9: Mode codes 0 (register) and 1 (immediate), and the reserved code 7, drive `out_mem` low and report `out_offset`=0 and `out_phys`=0. The override input has no effect on these outputs.
- R10: A request accepted on a clock edge (`in_valid` and `in_ready` high) appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold steady and `in_ready` is low.
- R11: While reset is active and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| mode | input | 3 | Addressing-mode code |
| ind_sel | input | 2 | Pointer for register-indirect mode |
| base_sel | input | 1 | 0 BX, 1 BP |
| idx_sel | input | 1 | 0 SI, 1 DI |
| disp | input | 16 | Displacement or direct offset |
| disp_wide | input | 1 | 1 uses 16-bit displacement, 0 sign-extends low byte |
| seg_ovr_en | input | 1 | Segment override active |
| seg_ovr_sel | input | 2 | Override segment code |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_mem | output | 1 | Memory access required |
| out_seg_sel | output | 2 | Segment code used |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |

## Verification
The assertions assume the consumer raises `out_ready` freely. They compare each result with the request inputs captured on the accepting edge, so they rely on `mode`, `disp` and the override fields being steady across that edge. The bench drives every input on the falling clock edge and holds it until the next falling edge. It changes the register and segment values only while no request is pending, so each expected result is built from one consistent register snapshot.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the effective address generator.
// Assumes: mode and segment codes are fixed by the decoder contract.
package agu_pkg;
    typedef enum logic [2:0] {
        AM_REG      = 3'd0,
        AM_IMM      = 3'd1,
        AM_DIRECT   = 3'd2,
        AM_REGIND   = 3'd3,
        AM_BASED    = 3'd4,
        AM_INDEXED  = 3'd5,
        AM_BASEIDX  = 3'd6,
        AM_RSVD     = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_e;
endpackage

// File: rtl/agu_offset_calc.sv
// Module: agu_offset_calc
// Forms the 16-bit effective offset for every memory addressing mode.
// It also says whether BP took part (which sets the default segment) and
// whether a memory access exists at all.
// Assumes: SHORT_W < OFS_W; the sums wrap at OFS_W bits.
module agu_offset_calc
    import agu_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]       mode,
    input  logic [1:0]       ind_sel,
    input  logic             base_sel,
    input  logic             idx_sel,
    input  logic [OFS_W-1:0] disp,
    input  logic             disp_wide,
    input  logic [OFS_W-1:0] reg_bx,
    input  logic [OFS_W-1:0] reg_bp,
    input  logic [OFS_W-1:0] reg_si,
    input  logic [OFS_W-1:0] reg_di,
    output logic [OFS_W-1:0] ofs,
    output logic             mem_acc,
    output logic             uses_bp
);
    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] base_val;
    logic [OFS_W-1:0] idx_val;
    logic [OFS_W-1:0] ind_val;

    // Widen the displacement: either full width or a sign-extended short form.
    always_comb begin
        if (disp_wide) disp_ext = disp;
        else           disp_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end

    // Select the base and index operands.
    always_comb begin
        base_val = base_sel ? reg_bp : reg_bx;
        idx_val  = idx_sel  ? reg_di : reg_si;
    end

    // Select the pointer for register-indirect mode.
    always_comb begin
        unique case (ind_sel)
            2'd0:    ind_val = reg_bx;
            2'd1:    ind_val = reg_bp;
            2'd2:    ind_val = reg_si;
            default: ind_val = reg_di;
        endcase
    end

    // Combine operands per mode; non-memory modes yield zero.
    always_comb begin
        ofs     = '0;
        mem_acc = 1'b0;
        uses_bp = 1'b0;
        unique case (amode_e'(mode))
            AM_DIRECT: begin
                ofs     = disp;
                mem_acc = 1'b1;
            end
            AM_REGIND: begin
                ofs     = ind_val;
                mem_acc = 1'b1;
                uses_bp = (ind_sel == 2'd1);
            end
            AM_BASED: begin
                ofs     = base_val + disp_ext;
                mem_acc = 1'b1;
                uses_bp = base_sel;
            end
            AM_INDEXED: begin
                ofs     = idx_val + disp_ext;
                mem_acc = 1'b1;
            end
            AM_BASEIDX: begin
                ofs     = base_val + idx_val;
                mem_acc = 1'b1;
                uses_bp = base_sel;
            end
            default: begin
                ofs     = '0;
                mem_acc = 1'b0;
                uses_bp = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_seg_select.sv
// Module: agu_seg_select
// Picks the segment code and its value: stack when BP took part, data
// otherwise. An enabled override replaces that choice.
// Assumes: segment codes 0..3 map to ES, CS, SS, DS.
module agu_seg_select
    import agu_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             uses_bp,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    input  logic [SEG_W-1:0] seg_es,
    input  logic [SEG_W-1:0] seg_cs,
    input  logic [SEG_W-1:0] seg_ss,
    input  logic [SEG_W-1:0] seg_ds,
    output logic [1:0]       seg_code,
    output logic [SEG_W-1:0] seg_val
);
    // Default-or-override segment choice.
    always_comb begin
        if (ovr_en)       seg_code = ovr_sel;
        else if (uses_bp) seg_code = SEG_STACK;
        else              seg_code = SEG_DATA;
    end

    // Look up the value of the chosen segment register.
    always_comb begin
        unique case (seg_e'(seg_code))
            SEG_EXTRA: seg_val = seg_es;
            SEG_CODE:  seg_val = seg_cs;
            SEG_STACK: seg_val = seg_ss;
            default:   seg_val = seg_ds;
        endcase
    end
endmodule

// File: rtl/agu_phys_calc.sv
// Module: agu_phys_calc
// Shifts the segment value left by SEG_SHIFT, adds the offset, and keeps
// the low PA_W bits. A gate forces zero when no memory access exists.
// Assumes: PA_W <= SEG_W + SEG_SHIFT and OFS_W <= SEG_W + SEG_SHIFT.
module agu_phys_calc #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20
) (
    input  logic             mem_acc,
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  phys
);
    localparam int SUM_W = SEG_W + SEG_SHIFT;

    logic [SUM_W-1:0] sum;

    // Full-width sum of the shifted segment and the zero-extended offset.
    always_comb begin
        sum = {seg_val, {SEG_SHIFT{1'b0}}} + {{(SUM_W-OFS_W){1'b0}}, ofs};
    end

    // Truncate to the physical width; zero for non-memory requests.
    always_comb begin
        phys = mem_acc ? sum[PA_W-1:0] : '0;
    end
endmodule

// File: rtl/agu_out_stage.sv
// Module: agu_out_stage
// A one-entry register stage with valid/ready on both sides. It takes a
// new word when empty, or on the same edge the held word is consumed.
// Assumes: synchronous active-low reset.
module agu_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic load;

    // Ready when empty or when the held word leaves this cycle.
    always_comb begin
        in_ready = !out_valid || out_ready;
        load     = in_valid && in_ready;
    end

    // Hold register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/agu_ea_unit.sv
// Module: agu_ea_unit (top)
// Effective and physical address generator for a segmented 16-bit
// machine. It chains the offset, segment and physical-address logic into
// one registered handshake stage.
// Assumes: register and segment inputs are steady on the accepting edge.
module agu_ea_unit #(
    parameter int OFS_W     = 16,
    parameter int SHORT_W   = 8,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       mode,
    input  logic [1:0]       ind_sel,
    input  logic             base_sel,
    input  logic             idx_sel,
    input  logic [OFS_W-1:0] disp,
    input  logic             disp_wide,
    input  logic             seg_ovr_en,
    input  logic [1:0]       seg_ovr_sel,
    input  logic [OFS_W-1:0] reg_bx,
    input  logic [OFS_W-1:0] reg_bp,
    input  logic [OFS_W-1:0] reg_si,
    input  logic [OFS_W-1:0] reg_di,
    input  logic [OFS_W-1:0] seg_es,
    input  logic [OFS_W-1:0] seg_cs,
    input  logic [OFS_W-1:0] seg_ss,
    input  logic [OFS_W-1:0] seg_ds,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_mem,
    output logic [1:0]       out_seg_sel,
    output logic [OFS_W-1:0] out_offset,
    output logic [PA_W-1:0]  out_phys
);
    localparam int PAY_W = 1 + 2 + OFS_W + PA_W;

    logic [OFS_W-1:0] c_ofs;
    logic             c_mem;
    logic             c_bp;
    logic [1:0]       c_seg;
    logic [OFS_W-1:0] c_segval;
    logic [PA_W-1:0]  c_phys;
    logic [PAY_W-1:0] c_pay;
    logic [PAY_W-1:0] r_pay;

    agu_offset_calc #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ofs (
        .mode(mode), .ind_sel(ind_sel), .base_sel(base_sel), .idx_sel(idx_sel),
        .disp(disp), .disp_wide(disp_wide),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .ofs(c_ofs), .mem_acc(c_mem), .uses_bp(c_bp)
    );

    agu_seg_select #(.SEG_W(OFS_W)) u_seg (
        .uses_bp(c_bp), .ovr_en(seg_ovr_en), .ovr_sel(seg_ovr_sel),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .seg_code(c_seg), .seg_val(c_segval)
    );

    agu_phys_calc #(.SEG_W(OFS_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_phys (
        .mem_acc(c_mem), .seg_val(c_segval), .ofs(c_ofs), .phys(c_phys)
    );

    // Pack the combinational result for the register stage.
    always_comb begin
        c_pay = {c_mem, c_seg, c_ofs, c_phys};
    end

    agu_out_stage #(.W(PAY_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(c_pay),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(r_pay)
    );

    // Unpack the registered result onto the output ports.
    always_comb begin
        {out_mem, out_seg_sel, out_offset, out_phys} = r_pay;
    end
endmodule

// File: rtl/agu_ea_unit_chk.sv
// Module: agu_ea_unit_chk
// Temporal checks on the address generator's handshake and results,
// bound to the top module.
// Assumes: request fields are steady across the accepting edge.
module agu_ea_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [2:0]  mode,
    input logic [15:0] disp,
    input logic        seg_ovr_en,
    input logic [1:0]  seg_ovr_sel,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_mem,
    input logic [1:0]  out_seg_sel,
    input logic [15:0] out_offset,
    input logic [19:0] out_phys
);
    // R10
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_phys)
            && $stable(out_seg_sel) && $stable(out_mem));

    // R10
    stall_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R1
    direct_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && mode == 3'd2 |=> out_mem && out_offset == $past(disp));

    // R9
    no_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (mode <= 3'd1 || mode == 3'd7)
            |=> !out_mem && out_offset == 16'd0 && out_phys == 20'd0);

    // R8
    override_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && seg_ovr_en && mode >= 3'd2 && mode <= 3'd6
            |=> out_seg_sel == $past(seg_ovr_sel));
endmodule

bind agu_ea_unit agu_ea_unit_chk u_chk (.*);

// File: tb/agu_ea_unit_tb.sv
module agu_ea_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  mode = '0;
    logic [1:0]  ind_sel = '0;
    logic        base_sel = 1'b0;
    logic        idx_sel = 1'b0;
    logic [15:0] disp = '0;
    logic        disp_wide = 1'b0;
    logic        seg_ovr_en = 1'b0;
    logic [1:0]  seg_ovr_sel = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_mem;
    logic [1:0]  out_seg_sel;
    logic [15:0] out_offset;
    logic [19:0] out_phys;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    agu_ea_unit u_dut (.*);

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result packed as {mem, seg, offset, phys}, built from the requirements.
    function automatic logic [38:0] model();
        logic [15:0] ofs, dx, b, x, sv;
        logic [1:0]  sg;
        logic        mem;
        int          pa;
        dx = disp_wide ? disp : {{8{disp[7]}}, disp[7:0]};
        b  = base_sel ? reg_bp : reg_bx;
        x  = idx_sel ? reg_di : reg_si;
        mem = 1'b1; sg = 2'd3; ofs = 16'd0;
        case (mode)
            3'd2: ofs = disp;
            3'd3: begin
                ofs = (ind_sel == 0) ? reg_bx : (ind_sel == 1) ? reg_bp :
                      (ind_sel == 2) ? reg_si : reg_di;
                if (ind_sel == 1) sg = 2'd2;
            end
            3'd4: begin ofs = b + dx; if (base_sel) sg = 2'd2; end
            3'd5: ofs = x + dx;
            3'd6: begin ofs = b + x; if (base_sel) sg = 2'd2; end
            default: mem = 1'b0;
        endcase
        if (mem && seg_ovr_en) sg = seg_ovr_sel;
        sv = (sg == 0) ? seg_es : (sg == 1) ? seg_cs : (sg == 2) ? seg_ss : seg_ds;
        pa = (int'(sv) * 16 + int'(ofs)) % (1 << 20);
        if (!mem) begin pa = 0; ofs = 16'd0; end
        return {mem, sg, ofs, pa[19:0]};
    endfunction

    // One request with the consumer ready, then compare the registered result.
    task automatic xfer(input string tag);
        logic [38:0] e;
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1;
        e = model();
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {39'd0, out_valid}, 40'd1);
        if (e[38]) check({tag, " result"}, {1'b0, out_mem, out_seg_sel, out_offset, out_phys}, {1'b0, e});
        else check({tag, " result"}, {1'b0, out_mem, 2'b00, out_offset, out_phys}, {1'b0, e[38], 2'b00, e[35:0]});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R11 reset valid", {39'd0, out_valid}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 post-reset ready", {38'd0, out_valid, in_ready}, 40'd1);
    endtask

    task automatic t_direct();
        seg_ds = 16'h2000; mode = 3'd2; disp = 16'h1234; disp_wide = 1'b1;
        xfer("R1 R7 direct");
        disp = 16'hFFFE;
        xfer("R1 direct high");
    endtask

    task automatic t_regind();
        reg_bx = 16'h0100; reg_bp = 16'h0200; reg_si = 16'h0300; reg_di = 16'h0400;
        seg_ss = 16'h3000; mode = 3'd3;
        for (int i = 0; i < 4; i++) begin
            ind_sel = 2'(i);
            xfer($sformatf("R2 regind sel%0d", i));
        end
    endtask

    task automatic t_based();
        mode = 3'd4;
        base_sel = 1'b0; disp = 16'h0456; disp_wide = 1'b1;
        xfer("R3 BX wide");
        base_sel = 1'b1; disp = 16'h55F0; disp_wide = 1'b0;
        xfer("R3 BP short negative");
        base_sel = 1'b1; disp = 16'hAA7F; disp_wide = 1'b0;
        xfer("R3 BP short positive");
    endtask

    task automatic t_indexed();
        mode = 3'd5;
        idx_sel = 1'b0; disp = 16'h0008; disp_wide = 1'b0;
        xfer("R4 SI short");
        idx_sel = 1'b1; disp = 16'h1234; disp_wide = 1'b1;
        xfer("R4 DI wide");
    endtask

    task automatic t_baseidx();
        mode = 3'd6; disp = 16'h7777;
        base_sel = 1'b0; idx_sel = 1'b0;
        xfer("R5 BX+SI");
        base_sel = 1'b1; idx_sel = 1'b1;
        xfer("R5 BP+DI");
    endtask

    task automatic t_wrap();
        reg_bx = 16'hFFF0; mode = 3'd4; base_sel = 1'b0; disp = 16'h0020; disp_wide = 1'b0;
        xfer("R6 offset wrap");
        seg_ds = 16'hFFFF; mode = 3'd2; disp = 16'h0020; disp_wide = 1'b1;
        xfer("R7 physical wrap");
    endtask

    task automatic t_override();
        seg_es = 16'h4000; seg_cs = 16'h5000;
        mode = 3'd4; base_sel = 1'b1; disp = 16'h0010; disp_wide = 1'b1;
        seg_ovr_en = 1'b1; seg_ovr_sel = 2'd0;
        xfer("R8 BP override ES");
        mode = 3'd2; seg_ovr_sel = 2'd1;
        xfer("R8 direct override CS");
        seg_ovr_en = 1'b0;
    endtask

    task automatic t_nomem();
        seg_ovr_en = 1'b1; seg_ovr_sel = 2'd2; disp = 16'h1111;
        mode = 3'd0; xfer("R9 register mode");
        mode = 3'd1; xfer("R9 immediate mode");
        mode = 3'd7; xfer("R9 reserved mode");
        seg_ovr_en = 1'b0;
    endtask

    task automatic t_handshake();
        logic [38:0] ea, eb;
        @(negedge clk);
        mode = 3'd2; disp = 16'h0A0A; disp_wide = 1'b1; seg_ds = 16'h1000;
        in_valid = 1'b1; out_ready = 1'b0;
        ea = model();
        @(negedge clk);
        check("R10 first result", {out_valid, out_mem, out_seg_sel, out_offset, out_phys}, {1'b1, ea});
        check("R10 stalled ready low", {39'd0, in_ready}, 40'd0);
        disp = 16'h0B0B;
        eb = model();
        @(negedge clk);
        check("R10 held while stalled", {out_valid, out_mem, out_seg_sel, out_offset, out_phys}, {1'b1, ea});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second after release", {out_valid, out_mem, out_seg_sel, out_offset, out_phys}, {1'b1, eb});
        @(negedge clk);
        check("R10 drained", {39'd0, out_valid}, 40'd0);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_regind();
        t_based();
        t_indexed();
        t_baseidx();
        t_wrap();
        t_override();
        t_nomem();
        t_handshake();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule